// File: doc/BRIEF.md
# Debounced Edge Interrupt Detector

This block conditions one general-purpose input pin and turns its transitions into interrupt events. The raw pin first passes through a two-flop synchronizer. A debounce filter can then be enabled. It holds a filtered level that follows the synchronized input only after the input has stayed different from it for a programmable number of millisecond ticks. An edge stage compares the filtered level with its previous value. It emits a one-cycle event pulse when the change matches the selected direction. A status register outside this block uses that pulse to set the pin's interrupt flag.

Configuration comes from the pin's 9-bit control word, which is decoded in place. Bits [4:3] select the edge. Bit 8 enables debouncing. Bits [7:5] hold an exponent n, and the debounce period is 2^n ticks, which gives 1 to 128 ms when `ms_tick` pulses once per millisecond. Bits [2:0] are not used here. The block does not support level-sensitive triggering. A change of the decoded configuration restarts the debounce count and never counts as an interrupt.

Top module: `pin_edge_irq`

## Requirements
- R1: The pin is synchronized through two flops. With debounce disabled, a pin change that is set up before a rising clock edge shows as `evt_pulse` high during the cycle that follows the third rising edge from that point.
- R2: The edge select is ctrl[4:3]. Code 1 fires on a 0-to-1 change of the filtered level only, code 2 on a 1-to-0 change only, and code 3 on both.
- R3: Edge select code 0 produces no events at all.
- R4: Each change of the filtered level produces exactly one event, and that event is one cycle wide.
- R5: When ctrl[8] is 0 the filter is bypassed, and the filtered level equals the synchronized input one clock later.
- R6: When ctrl[8] is 1 and ctrl[7:5] = n, the filtered level takes the synchronized value on the clock edge where the 2^n-th `ms_tick` is counted while the two levels differ.
- R7: If the synchronized input returns to the filtered level before the period completes, the count goes back to zero.
- R8: A change of the decoded configuration (select, enable, exponent) clears the count and raises no event, including when it disables debouncing and the filtered level jumps.
- R9: With debounce enabled, the filtered level never changes on a cycle without `ms_tick`, and it never changes while the synchronized input equals it.
- R10: After reset `evt_pulse` is 0 and the filtered level is 0. Writes to ctrl[2:0] alone are ignored: they do not restart the debounce count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | 1 | Raw asynchronous pin level |
| ms_tick | input | 1 | One-cycle pulse per millisecond that paces debounce |
| ctrl | input | 9 | Pin control word (edge select, debounce enable, exponent) |
| evt_pulse | output | 1 | One-cycle interrupt event |

## Verification
Two things can happen on the same clock edge: a control-word update and a filtered-level change that the debounce counter or the bypass path would otherwise commit. The bench provokes this in two directed ways. It switches the exponent midway through a count. It also disables debouncing while the pin already differs from the held level. The random phase adds further collisions by rewriting the control word while a count is running. A cycle model in the bench, built from the requirements, predicts every cycle of `evt_pulse`. A collision is judged correct when the count restarts and the silent level jump produces no pulse.

// File: rtl/pin_evt_pkg.sv
package pin_evt_pkg;

    localparam int CTRL_W   = 9;
    localparam int SEL_LSB  = 3;
    localparam int EXP_LSB  = 5;
    localparam int EXP_W    = 3;
    localparam int DBEN_BIT = 8;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_RISE = 2'd1,
        SEL_FALL = 2'd2,
        SEL_BOTH = 2'd3
    } edge_sel_e;

    typedef struct packed {
        edge_sel_e        sel;
        logic             db_en;
        logic [EXP_W-1:0] exp_code;
    } pin_cfg_t;

    function automatic pin_cfg_t decode_ctrl(input logic [CTRL_W-1:0] word);
        pin_cfg_t c;
        c.sel      = edge_sel_e'(word[SEL_LSB +: 2]);
        c.db_en    = word[DBEN_BIT];
        c.exp_code = word[EXP_LSB +: EXP_W];
        return c;
    endfunction

    function automatic logic edge_hit(input edge_sel_e s, input logic now_lvl);
        logic r;
        case (s)
            SEL_RISE: r = now_lvl;
            SEL_FALL: r = !now_lvl;
            SEL_BOTH: r = 1'b1;
            default:  r = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES < 2) begin : g_bad
            initial $error("pin_sync needs at least two stages");
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], din};
    end

    assign dout = chain[STAGES-1];

endmodule

// File: rtl/debounce_filter.sv
module debounce_filter #(
    parameter int EXP_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             din,
    input  logic             tick,
    input  logic             cfg_chg,
    input  logic             db_en,
    input  logic [EXP_W-1:0] exp_code,
    output logic             level,
    output logic             quiet
);
    localparam int CNT_W = 2 ** EXP_W;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W:0]   target;
    logic [CNT_W:0]   next_cnt;
    logic             done;

    assign target   = {{CNT_W{1'b0}}, 1'b1} << exp_code;
    assign next_cnt = {1'b0, cnt} + {{CNT_W{1'b0}}, 1'b1};
    assign done     = (next_cnt == target);

    always_ff @(posedge clk) begin
        if (rst) begin
            level <= 1'b0;
            cnt   <= '0;
            quiet <= 1'b0;
        end else begin
            quiet <= cfg_chg;
            if (cfg_chg) begin
                cnt <= '0;
                if (!db_en) level <= din;
            end else if (!db_en) begin
                level <= din;
                cnt   <= '0;
            end else if (din == level) begin
                cnt <= '0;
            end else if (tick) begin
                if (done) begin
                    level <= din;
                    cnt   <= '0;
                end else begin
                    cnt <= next_cnt[CNT_W-1:0];
                end
            end
        end
    end

    // R5: bypass path follows the synchronized input one cycle later
    a_r5_bypass: assert property (@(posedge clk) disable iff (rst)
        (!db_en && !cfg_chg) |=> (level == $past(din)));
    // R9: no change without a tick while filtering
    a_r9_needs_tick: assert property (@(posedge clk) disable iff (rst)
        (db_en && !cfg_chg && !tick) |=> $stable(level));
    // R9: equal input holds the level
    a_r9_equal_hold: assert property (@(posedge clk) disable iff (rst)
        (db_en && !cfg_chg && (din == level)) |=> $stable(level));
    // R8: configuration update with filtering on leaves the level alone
    a_r8_cfg_hold: assert property (@(posedge clk) disable iff (rst)
        (cfg_chg && db_en) |=> $stable(level));

endmodule

// File: rtl/edge_event.sv
module edge_event
    import pin_evt_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      level,
    input  logic      quiet,
    input  edge_sel_e sel,
    output logic      evt
);
    logic prev;

    always_ff @(posedge clk) begin
        if (rst) prev <= 1'b0;
        else     prev <= level;
    end

    assign evt = (level != prev) && !quiet && edge_hit(sel, level);

    // R2: rising select only reports a high filtered level
    a_r2_rise_level: assert property (@(posedge clk) disable iff (rst)
        (evt && sel == SEL_RISE) |-> level);
    // R2: falling select only reports a low filtered level
    a_r2_fall_level: assert property (@(posedge clk) disable iff (rst)
        (evt && sel == SEL_FALL) |-> !level);

endmodule

// File: rtl/pin_edge_irq.sv
module pin_edge_irq
    import pin_evt_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pin_in,
    input  logic              ms_tick,
    input  logic [CTRL_W-1:0] ctrl,
    output logic              evt_pulse
);
    pin_cfg_t cfg_now;
    pin_cfg_t cfg_q;
    logic     cfg_chg;
    logic     pin_s;
    logic     lvl;
    logic     quiet;

    assign cfg_now = decode_ctrl(ctrl);
    assign cfg_chg = (cfg_now != cfg_q);

    always_ff @(posedge clk) begin
        if (rst) cfg_q <= '0;
        else     cfg_q <= cfg_now;
    end

    pin_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk  (clk),
        .rst  (rst),
        .din  (pin_in),
        .dout (pin_s)
    );

    debounce_filter #(.EXP_W(EXP_W)) filt_i (
        .clk      (clk),
        .rst      (rst),
        .din      (pin_s),
        .tick     (ms_tick),
        .cfg_chg  (cfg_chg),
        .db_en    (cfg_now.db_en),
        .exp_code (cfg_now.exp_code),
        .level    (lvl),
        .quiet    (quiet)
    );

    edge_event edge_i (
        .clk   (clk),
        .rst   (rst),
        .level (lvl),
        .quiet (quiet),
        .sel   (cfg_q.sel),
        .evt   (evt_pulse)
    );

    // R8: a configuration update never yields an event
    a_r8_cfg_silent: assert property (@(posedge clk) disable iff (rst)
        cfg_chg |=> !evt_pulse);
    // R3: a steady code-0 select yields no event
    a_r3_sel_off: assert property (@(posedge clk) disable iff (rst)
        (cfg_now.sel == SEL_NONE && !cfg_chg) |=> !evt_pulse);

endmodule

// File: tb/pin_edge_irq_tb_top.sv
module pin_edge_irq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    logic       clk;
    logic       rst;
    logic       pin_r;
    logic       tick_r;
    logic [8:0] ctrl_r;
    logic       evt;

    int checks = 0;
    int errors = 0;
    int ev_seen = 0;
    bit done = 0;

    // bench model state
    bit m_s1, m_s2, m_lvl, m_prev, m_quiet, m_evt;
    int m_cnt;
    bit [1:0] q_sel;
    bit q_en;
    bit [2:0] q_exp;

    pin_edge_irq dut_i (
        .clk       (clk),
        .rst       (rst),
        .pin_in    (pin_r),
        .ms_tick   (tick_r),
        .ctrl      (ctrl_r),
        .evt_pulse (evt)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic bit sel_match(input bit [1:0] s, input bit lvl);
        if (s == 2'd3) return 1'b1;
        if (s == 2'd1) return lvl;
        if (s == 2'd2) return !lvl;
        return 1'b0;
    endfunction

    task automatic model_update();
        bit [1:0] nsel = ctrl_r[4:3];
        bit nen = ctrl_r[8];
        bit [2:0] nexp = ctrl_r[7:5];
        bit chg = ({nsel, nen, nexp} != {q_sel, q_en, q_exp});
        bit old_lvl = m_lvl;
        bit din = m_s2;
        if (chg) begin
            m_cnt = 0;
            if (!nen) m_lvl = din;
        end else if (!nen) begin
            m_lvl = din;
            m_cnt = 0;
        end else if (din == m_lvl) begin
            m_cnt = 0;
        end else if (tick_r) begin
            if (m_cnt + 1 == (1 << nexp)) begin
                m_lvl = din;
                m_cnt = 0;
            end else begin
                m_cnt = m_cnt + 1;
            end
        end
        m_s2 = m_s1;
        m_s1 = pin_r;
        m_prev = old_lvl;
        m_quiet = chg;
        q_sel = nsel; q_en = nen; q_exp = nexp;
        m_evt = (m_lvl != m_prev) && !m_quiet && sel_match(q_sel, m_lvl);
    endtask

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(input string tag);
        @(posedge clk);
        @(negedge clk);
        model_update();
        check(evt === m_evt, tag, int'(evt), int'(m_evt));
        if (evt === 1'b1) ev_seen++;
    endtask

    task automatic run(input int n, input string tag);
        for (int i = 0; i < n; i++) step(tag);
    endtask

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got 0 expected 1 (run finished)");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        rst = 1'b1; pin_r = 1'b0; tick_r = 1'b0; ctrl_r = 9'h000;
        repeat (4) @(negedge clk);
        m_s1 = 0; m_s2 = 0; m_lvl = 0; m_prev = 0; m_quiet = 0; m_evt = 0; m_cnt = 0;
        q_sel = 0; q_en = 0; q_exp = 0;
        check(evt === 1'b0, "R10 reset", int'(evt), 0);
        rst = 1'b0;
        run(3, "R10");

        // R1: bypass latency, rising select
        ctrl_r = 9'h008;
        run(3, "R1");
        pin_r = 1'b1;
        step("R1"); check(evt === 1'b0, "R1 cycle1", int'(evt), 0);
        step("R1"); check(evt === 1'b0, "R1 cycle2", int'(evt), 0);
        step("R1"); check(evt === 1'b1, "R1 cycle3", int'(evt), 1);
        step("R4"); check(evt === 1'b0, "R4 one cycle", int'(evt), 0);
        ev_seen = 0;
        pin_r = 1'b0; run(6, "R2");
        check(ev_seen == 0, "R2 rise ignores fall", ev_seen, 0);

        // R2: falling select
        ctrl_r = 9'h010; run(3, "R2");
        ev_seen = 0;
        pin_r = 1'b1; run(6, "R2");
        pin_r = 1'b0; run(6, "R2");
        check(ev_seen == 1, "R2 fall count", ev_seen, 1);

        // R2/R4: both edges
        ctrl_r = 9'h018; run(3, "R2");
        ev_seen = 0;
        pin_r = 1'b1; run(6, "R4");
        pin_r = 1'b0; run(6, "R4");
        check(ev_seen == 2, "R4 both count", ev_seen, 2);

        // R3: select off
        ctrl_r = 9'h000; run(3, "R3");
        ev_seen = 0;
        pin_r = 1'b1; run(6, "R3");
        pin_r = 1'b0; run(6, "R3");
        check(ev_seen == 0, "R3 off count", ev_seen, 0);

        // R6: debounce 2^2 ticks, tick every cycle
        ctrl_r = 9'h158; tick_r = 1'b1; run(3, "R6");
        pin_r = 1'b1;
        for (int i = 1; i <= 5; i++) begin
            step("R6"); check(evt === 1'b0, "R6 waiting", int'(evt), 0);
        end
        step("R6"); check(evt === 1'b1, "R6 period done", int'(evt), 1);

        // R9: no ticks, no change
        tick_r = 1'b0; ev_seen = 0;
        pin_r = 1'b0; run(20, "R9");
        check(ev_seen == 0, "R9 no tick", ev_seen, 0);
        tick_r = 1'b1; run(8, "R9");
        check(ev_seen == 1, "R9 ticks resume", ev_seen, 1);

        // R7: bounce restarts count
        ev_seen = 0;
        pin_r = 1'b1; run(2, "R7");
        pin_r = 1'b0; run(15, "R7");
        check(ev_seen == 0, "R7 bounce filtered", ev_seen, 0);
        pin_r = 1'b1; run(10, "R7");
        check(ev_seen == 1, "R7 steady accepted", ev_seen, 1);

        // R10: ctrl[2:0] ignored mid count
        pin_r = 1'b0;
        step("R10"); step("R10"); step("R10");
        ctrl_r = 9'h15F;
        step("R10"); step("R10");
        check(evt === 1'b0, "R10 not yet", int'(evt), 0);
        step("R10"); check(evt === 1'b1, "R10 timing kept", int'(evt), 1);

        // R8: exponent change mid count restarts
        ctrl_r = 9'h158; run(3, "R8");
        pin_r = 1'b1; run(4, "R8");
        ctrl_r = 9'h178; ev_seen = 0;
        run(7, "R8");
        check(ev_seen == 0, "R8 restarted", ev_seen, 0);
        run(4, "R8");
        check(ev_seen == 1, "R8 after restart", ev_seen, 1);

        // R8: disabling debounce with a pending level is silent
        ctrl_r = 9'h1F8; tick_r = 1'b0; run(3, "R8");
        pin_r = 1'b0; run(6, "R8");
        ev_seen = 0;
        ctrl_r = 9'h018; run(5, "R8");
        check(ev_seen == 0, "R8 silent realign", ev_seen, 0);
        pin_r = 1'b1; run(6, "R5");
        check(ev_seen == 1, "R5 bypass event", ev_seen, 1);

        // random phase
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(0, 9) == 0) pin_r = ~pin_r;
            tick_r = ($urandom_range(0, 2) == 0);
            if ($urandom_range(0, 99) == 0)
                ctrl_r = {1'($urandom_range(0, 1)), 3'($urandom_range(0, 3)),
                          2'($urandom_range(0, 3)), 3'($urandom_range(0, 7))};
            step("R6");
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule